// File: doc/BRIEF.md
# Barrel Shifter with Processor Flag Update

This unit performs the shift and rotate step of a processor datapath on a 32-bit operand. It supports five operations: arithmetic right shift, logical left shift, logical right shift, rotate right, and a one-bit rotate right through the carry flag. The shift amount comes from one of two sources. One is a small immediate field. The other is the low byte of a register value, which allows amounts up to 255. The carry output follows the usual processor flag convention. The carry is kept when the amount is zero. Otherwise it takes the last bit that left the operand.

When flag update is enabled, the unit also produces new negative and zero flags from the result. When flag update is disabled, all three flags pass through unchanged. The shift network is purely combinational. A parameter adds a single output register stage so the unit can sit on a pipeline boundary. `DATA_W` must be a power of two, because rotation takes the amount modulo the data width.

Top module: `shift_flag_unit`

## Requirements
- R1: Logical left shift (op code 1) by an amount from 1 to 31 fills the vacated low bits with zeros. The carry becomes the last bit shifted out, which is operand bit 32 minus the amount.
- R2: Logical right shift (op code 2) by an amount from 1 to 31 fills the vacated high bits with zeros. The carry becomes operand bit (amount minus 1).
- R3: Arithmetic right shift (op code 0) fills the vacated high bits with the operand's bit 31. For amounts of 32 or more, the result is bit 31 copied into every position, and the carry equals bit 31.
- R4: Rotate right (op code 3) rotates by the amount modulo 32, and the carry for any nonzero amount equals result bit 31. A nonzero multiple of 32 leaves the operand unchanged, with carry equal to operand bit 31.
- R5: Rotate through carry (op code 4) ignores the amount. It returns the operand shifted right by one with the incoming carry in bit 31, and the carry output becomes old bit 0.
- R6: Logical left or right shift by exactly 32 gives a zero result. The carry is old bit 0 for left and old bit 31 for right. Either shift by 33 to 255 gives zero with carry zero.
- R7: With `amt_from_reg`=1, the amount is `reg_amt[7:0]` and bits above 7 have no effect. With `amt_from_reg`=0, the amount is the 6-bit immediate, taken unsigned from 0 to 63, so 32 is accepted.
- R8: An amount of zero on op codes 0 to 3 returns the operand unchanged and keeps the incoming carry. Op codes 5 to 7 behave the same way for any amount.
- R9: With `flag_upd`=1, `n_out` equals result bit 31, `z_out` is 1 exactly when the result is zero, and `c_out` is the shifter carry.
- R10: With `flag_upd`=0, `n_out`, `z_out` and `c_out` equal `n_in`, `z_in` and `c_in`.
- R11: With `OUT_REG`=1 (default), all outputs appear one clock after their inputs and are zero while `rst_n` is low. With `OUT_REG`=0, the outputs are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 3 | Operation: 0 arith right, 1 logical left, 2 logical right, 3 rotate, 4 rotate through carry |
| opnd | input | DATA_W | Operand to shift |
| amt_from_reg | input | 1 | 1 selects the register amount, 0 selects the immediate |
| imm_amt | input | IMM_W | Immediate shift amount |
| reg_amt | input | DATA_W | Register value whose low byte is the amount |
| flag_upd | input | 1 | 1 updates N, Z and C from the operation |
| n_in | input | 1 | Incoming negative flag |
| z_in | input | 1 | Incoming zero flag |
| c_in | input | 1 | Incoming carry flag |
| result | output | DATA_W | Shifted or rotated result |
| n_out | output | 1 | Negative flag out |
| z_out | output | 1 | Zero flag out |
| c_out | output | 1 | Carry flag out |

## Verification
The unit holds no state beyond the output stage, so any fault shows at the ports on the very next clock after the offending inputs. Wrong fill bits, a wrong carry position, or an incorrect saturation at 32 therefore appear at once. The faults most likely to stay hidden are those at the amount edges: 0, 31, 32, 33 and 255, and multiples of 32 for rotation. The stimulus aims at these edges directly and also includes register values with garbage above bit 7. A corrupted output register would show up as a one-cycle misalignment between inputs and outputs. The bench checks for this by looking at the outputs just before each capture edge.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;
  typedef enum logic [2:0] {
    OP_ASR = 3'd0,
    OP_LSL = 3'd1,
    OP_LSR = 3'd2,
    OP_ROR = 3'd3,
    OP_RRX = 3'd4
  } shift_op_e;
endpackage

// File: rtl/shift_amt_select.sv
module shift_amt_select #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 6,
  parameter int AMT_W  = 8
) (
  input  logic              amt_from_reg,
  input  logic [IMM_W-1:0]  imm_amt,
  input  logic [DATA_W-1:0] reg_amt,
  output logic [AMT_W-1:0]  amt
);
  // only the low byte of the register is meaningful
  logic unused_reg_hi;
  assign unused_reg_hi = ^reg_amt[DATA_W-1:AMT_W];

  always_comb begin
    if (amt_from_reg) amt = reg_amt[AMT_W-1:0];
    else              amt = AMT_W'(imm_amt);
  end
endmodule

// File: rtl/shift_core.sv
module shift_core
  import shift_unit_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] opnd,
  input  logic [2:0]        op,
  input  logic [AMT_W-1:0]  amt,
  input  logic              carry_in,
  output logic [DATA_W-1:0] res,
  output logic              carry
);
  localparam int SH_W = $clog2(DATA_W);

  // one extra bit on each wide vector catches the last bit shifted out
  logic [DATA_W:0]   lsl_w, lsr_w, asr_w;
  logic [DATA_W-1:0] ror_v;
  logic [SH_W-1:0]   rot;

  always_comb begin
    lsl_w = {1'b0, opnd} << amt;
    lsr_w = {opnd, 1'b0} >> amt;
    asr_w = $unsigned($signed({opnd, 1'b0}) >>> amt);
    rot   = amt[SH_W-1:0];
    ror_v = (opnd >> rot) | (opnd << (DATA_W - int'(rot)));
  end

  always_comb begin
    res   = opnd;
    carry = carry_in;
    unique case (op)
      OP_ASR: if (amt != '0) begin
        res   = asr_w[DATA_W:1];
        carry = asr_w[0];
      end
      OP_LSL: if (amt != '0) begin
        res   = lsl_w[DATA_W-1:0];
        carry = lsl_w[DATA_W];
      end
      OP_LSR: if (amt != '0) begin
        res   = lsr_w[DATA_W:1];
        carry = lsr_w[0];
      end
      OP_ROR: if (amt != '0) begin
        res   = ror_v;
        carry = ror_v[DATA_W-1];
      end
      OP_RRX: begin
        res   = {carry_in, opnd[DATA_W-1:1]};
        carry = opnd[0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/shift_flag_update.sv
module shift_flag_update #(
  parameter int DATA_W = 32
) (
  input  logic              flag_upd,
  input  logic [DATA_W-1:0] res,
  input  logic              shift_c,
  input  logic              n_in,
  input  logic              z_in,
  input  logic              c_in,
  output logic              n_nxt,
  output logic              z_nxt,
  output logic              c_nxt
);
  always_comb begin
    if (flag_upd) begin
      n_nxt = res[DATA_W-1];
      z_nxt = (res == '0);
      c_nxt = shift_c;
    end else begin
      n_nxt = n_in;
      z_nxt = z_in;
      c_nxt = c_in;
    end
  end
endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit
  import shift_unit_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 6,
  parameter int AMT_W   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] opnd,
  input  logic              amt_from_reg,
  input  logic [IMM_W-1:0]  imm_amt,
  input  logic [DATA_W-1:0] reg_amt,
  input  logic              flag_upd,
  input  logic              n_in,
  input  logic              z_in,
  input  logic              c_in,
  output logic [DATA_W-1:0] result,
  output logic              n_out,
  output logic              z_out,
  output logic              c_out
);
  logic [AMT_W-1:0]  eff_amt;
  logic [DATA_W-1:0] res_nxt;
  logic              shift_c, n_nxt, z_nxt, c_nxt;

  shift_amt_select #(.DATA_W(DATA_W), .IMM_W(IMM_W), .AMT_W(AMT_W)) u_amt (
    .amt_from_reg(amt_from_reg), .imm_amt(imm_amt), .reg_amt(reg_amt), .amt(eff_amt)
  );

  shift_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
    .opnd(opnd), .op(op), .amt(eff_amt), .carry_in(c_in), .res(res_nxt), .carry(shift_c)
  );

  shift_flag_update #(.DATA_W(DATA_W)) u_flags (
    .flag_upd(flag_upd), .res(res_nxt), .shift_c(shift_c),
    .n_in(n_in), .z_in(z_in), .c_in(c_in),
    .n_nxt(n_nxt), .z_nxt(z_nxt), .c_nxt(c_nxt)
  );

  generate
    if (OUT_REG) begin : g_reg
      logic [DATA_W-1:0] res_q;
      logic              n_q, z_q, c_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          res_q <= '0;
          n_q   <= 1'b0;
          z_q   <= 1'b0;
          c_q   <= 1'b0;
        end else begin
          res_q <= res_nxt;
          n_q   <= n_nxt;
          z_q   <= z_nxt;
          c_q   <= c_nxt;
        end
      end
      assign result = res_q;
      assign n_out  = n_q;
      assign z_out  = z_q;
      assign c_out  = c_q;
    end else begin : g_comb
      assign result = res_nxt;
      assign n_out  = n_nxt;
      assign z_out  = z_nxt;
      assign c_out  = c_nxt;
    end
  endgenerate

  // zero amount keeps operand and carry
  p_zero_amt_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op <= 3'd3 && eff_amt == '0 && flag_upd) |-> (res_nxt == opnd && c_nxt == c_in));

  // flags pass through when update is off
  p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_upd |-> (n_nxt == n_in && z_nxt == z_in && c_nxt == c_in));

  p_rrx_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd4) |-> (res_nxt == {c_in, opnd[DATA_W-1:1]} && (!flag_upd || c_nxt == opnd[0])));

  p_logic_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == 3'd1 || op == 3'd2) && eff_amt > AMT_W'(DATA_W)) |->
      (res_nxt == '0 && (!flag_upd || !c_nxt)));

  p_asr_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd0 && eff_amt >= AMT_W'(DATA_W)) |-> (res_nxt == {DATA_W{opnd[DATA_W-1]}}));

  p_ror_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd3 && eff_amt != '0 && flag_upd) |-> (c_nxt == res_nxt[DATA_W-1]));
endmodule

// File: tb/shift_flag_unit_bench.sv
module shift_flag_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  op;
  logic [31:0] opnd, reg_amt;
  logic        amt_from_reg, flag_upd, n_in, z_in, c_in;
  logic [5:0]  imm_amt;
  logic [31:0] result;
  logic        n_out, z_out, c_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] prev_r;
  logic        prev_n, prev_z, prev_c;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_flag_unit u_shift_flag_unit (
    .clk(clk), .rst_n(rst_n), .op(op), .opnd(opnd), .amt_from_reg(amt_from_reg),
    .imm_amt(imm_amt), .reg_amt(reg_amt), .flag_upd(flag_upd),
    .n_in(n_in), .z_in(z_in), .c_in(c_in),
    .result(result), .n_out(n_out), .z_out(z_out), .c_out(c_out)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // bit-at-a-time behavioural model
  task automatic model(input logic [2:0] o, input logic [31:0] x, input int a,
                       input bit cin, input bit fe, input bit nin, input bit zin,
                       output logic [31:0] r, output bit c, output bit n, output bit z);
    r = x;
    c = cin;
    case (o)
      3'd0: for (int i = 0; i < a; i++) begin c = r[0]; r = {r[31], r[31:1]}; end
      3'd1: for (int i = 0; i < a; i++) begin c = r[31]; r = r << 1; end
      3'd2: for (int i = 0; i < a; i++) begin c = r[0]; r = r >> 1; end
      3'd3: for (int i = 0; i < a; i++) begin c = r[0]; r = {r[0], r[31:1]}; end
      3'd4: begin c = x[0]; r = {cin, x[31:1]}; end
      default: ;
    endcase
    if (fe) begin
      n = r[31];
      z = (r == 32'd0);
    end else begin
      n = nin;
      z = zin;
      c = cin;
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic apply(string tag, logic [2:0] o, logic [31:0] x, bit sel, logic [5:0] imm,
                       logic [31:0] rv, bit cin, bit fe, bit nin, bit zin);
    logic [31:0] er;
    bit ec, en, ez;
    int a;
    op = o; opnd = x; amt_from_reg = sel; imm_amt = imm; reg_amt = rv;
    c_in = cin; flag_upd = fe; n_in = nin; z_in = zin;
    a = sel ? int'(rv[7:0]) : int'(imm);
    model(o, x, a, cin, fe, nin, zin, er, ec, en, ez);
    #1;
    check("R11", "result before capture edge", result, prev_r);
    @(negedge clk);
    check(tag, "result", result, er);
    check(fe ? tag : "R10", "carry", {31'd0, c_out}, {31'd0, ec});
    check(fe ? "R9" : "R10", "negative", {31'd0, n_out}, {31'd0, en});
    check(fe ? "R9" : "R10", "zero", {31'd0, z_out}, {31'd0, ez});
    prev_r = er; prev_n = en; prev_z = ez; prev_c = ec;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R11 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    op = 3'd0; opnd = '0; amt_from_reg = 1'b0; imm_amt = '0; reg_amt = '0;
    flag_upd = 1'b0; n_in = 1'b0; z_in = 1'b0; c_in = 1'b0;
    prev_r = '0; prev_n = 1'b0; prev_z = 1'b0; prev_c = 1'b0;
    repeat (3) @(negedge clk);
    check("R11", "reset result", result, 32'd0);
    check("R11", "reset flags", {29'd0, n_out, z_out, c_out}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    apply("R1", 3'd1, 32'h8000_0001, 0, 6'd4,  32'h0, 0, 1, 0, 0);
    apply("R1", 3'd1, 32'h8000_0000, 0, 6'd1,  32'h0, 0, 1, 0, 0);
    apply("R1", 3'd1, 32'h0000_0003, 0, 6'd31, 32'h0, 1, 1, 0, 0);
    apply("R2", 3'd2, 32'h0000_0003, 0, 6'd1,  32'h0, 0, 1, 0, 0);
    apply("R2", 3'd2, 32'h8000_0000, 0, 6'd31, 32'h0, 0, 1, 0, 0);
    apply("R3", 3'd0, 32'h8000_00F0, 0, 6'd4,  32'h0, 0, 1, 0, 0);
    apply("R3", 3'd0, 32'h8000_0000, 0, 6'd32, 32'h0, 0, 1, 0, 0);
    apply("R3", 3'd0, 32'h7000_0000, 1, 6'd0,  32'd200, 1, 1, 0, 0);
    apply("R3", 3'd0, 32'hF000_0000, 1, 6'd0,  32'd255, 0, 1, 0, 0);
    apply("R4", 3'd3, 32'h1234_5678, 0, 6'd8,  32'h0, 0, 1, 0, 0);
    apply("R4", 3'd3, 32'h8000_0001, 1, 6'd0,  32'd32, 0, 1, 0, 0);
    apply("R4", 3'd3, 32'h0000_0001, 1, 6'd0,  32'd64, 0, 1, 0, 0);
    apply("R4", 3'd3, 32'h1234_5678, 1, 6'd0,  32'd40, 0, 1, 0, 0);
    apply("R5", 3'd4, 32'h0000_0001, 0, 6'd9,  32'h0, 1, 1, 0, 0);
    apply("R5", 3'd4, 32'h8000_0000, 1, 6'd0,  32'd0, 0, 1, 0, 0);
    apply("R6", 3'd1, 32'h0000_0001, 0, 6'd32, 32'h0, 0, 1, 0, 0);
    apply("R6", 3'd1, 32'hFFFF_FFFF, 1, 6'd0,  32'd33, 1, 1, 0, 0);
    apply("R6", 3'd2, 32'h8000_0000, 0, 6'd32, 32'h0, 0, 1, 0, 0);
    apply("R6", 3'd2, 32'hFFFF_FFFF, 1, 6'd0,  32'd255, 1, 1, 0, 0);
    apply("R6", 3'd2, 32'hFFFF_FFFF, 0, 6'd63, 32'h0, 1, 1, 0, 0);
    apply("R7", 3'd1, 32'h0000_00F1, 1, 6'd0,  32'hFFFF_FF04, 0, 1, 0, 0);
    apply("R7", 3'd2, 32'hF000_0000, 0, 6'd3,  32'h0000_0010, 0, 1, 0, 0);
    apply("R8", 3'd1, 32'hDEAD_BEEF, 0, 6'd0,  32'h0, 1, 1, 0, 0);
    apply("R8", 3'd0, 32'h8000_0001, 1, 6'd0,  32'h0000_0100, 0, 1, 0, 0);
    apply("R8", 3'd6, 32'h1357_9BDF, 0, 6'd5,  32'h0, 1, 1, 0, 0);
    apply("R9", 3'd2, 32'h0000_0001, 0, 6'd1,  32'h0, 0, 1, 0, 0);
    apply("R10", 3'd1, 32'h4000_0000, 0, 6'd2, 32'h0, 1, 0, 1, 0);
    apply("R10", 3'd2, 32'h0000_0000, 0, 6'd5, 32'h0, 0, 0, 0, 1);

    for (int k = 0; k < 400; k++) begin
      logic [2:0] o;
      string tg;
      o = 3'($urandom_range(0, 5));
      case (o)
        3'd0: tg = "R3";
        3'd1: tg = "R1";
        3'd2: tg = "R2";
        3'd3: tg = "R4";
        3'd4: tg = "R5";
        default: tg = "R8";
      endcase
      apply(tg, o, $urandom, 1'($urandom), 6'($urandom), $urandom,
            1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule